// File: doc/BRIEF.md
# Speed-Scaled PHY Data Lanes

This block sits between a link core and an 8-lane PHY data bus. The number of lanes that carry data depends on the transfer speed. On the transmit side it accepts one byte at a time over a valid/ready handshake. It cuts each byte into chunks of 2, 4 or 8 bits, sends the most significant chunk first, and drives each chunk onto the lanes starting from lane 0. The lanes that are not in use stay at zero. On the receive side it collects the chunks that arrive on the active lanes and puts them back together into bytes.

Both directions share one 2-bit speed input. Code 0 selects 100 Mbit/s (2 lanes, four cycles per byte). Code 1 selects 200 Mbit/s (4 lanes, two cycles per byte). Code 2 selects 400 Mbit/s (8 lanes, one cycle per byte). Code 3 is not supported. Each direction samples the speed code only on the byte or chunk that is flagged as the first of a packet. It keeps that code for the rest of the packet. Lane 0 is the most significant bit of the bus, which is bit 7 of every lane vector port. A transmit packet that starts at the unsupported code is rejected and raises a one-cycle error pulse.

Top module: `lane_speed_scaler`

## Requirements
- R1: After reset, `tx_lanes` is 0, `tx_lane_en` is 0, `tx_ready` is 1, `tx_err` is 0 and `rx_valid` is 0.
- R2: At speed code 0, an accepted byte appears on the bus over four consecutive cycles, starting the cycle after acceptance. Each cycle carries 2 bits on bits 7:6, most significant pair first, and bits 5:0 are held at 0.
- R3: At speed code 1, an accepted byte appears over two consecutive cycles on bits 7:4, upper nibble first, and bits 3:0 are held at 0.
- R4: At speed code 2, an accepted byte appears whole on bits 7:0 in the single cycle after acceptance.
- R5: `tx_ready` is low while further chunks of the current byte are still to be sent, and high during the last chunk. A byte offered then follows with no idle cycle. `tx_lane_en` is high exactly in the cycles that carry a chunk, and outside them `tx_lanes` is 0.
- R6: The transmit speed is captured only when a byte with `tx_first` high is accepted. A change on `spd` during the rest of the packet has no effect on the chunking.
- R7: A byte accepted with `tx_first` high while `spd` is 3 is dropped: `tx_err` is high for exactly the next cycle and no lane activity follows. Later bytes of that packet without `tx_first` are also dropped, with no error.
- R8: On receive, a byte is rebuilt from 4, 2 or 1 chunks at codes 0, 1 or 2. The first chunk becomes the most significant. `rx_valid` is high for one cycle, the cycle after the last chunk, with the byte on `rx_byte`.
- R9: On receive, the lanes below the active ones (bits 5:0 at code 0, bits 3:0 at code 1) are ignored.
- R10: The receive speed is captured on a chunk that has `rx_first` high, and it holds for the rest of the packet. A packet flagged at code 3 produces no `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| spd | input | 2 | Speed code: 0, 1, 2 legal; 3 unsupported |
| tx_valid | input | 1 | Transmit byte offered |
| tx_first | input | 1 | Offered byte starts a packet (speed sampled) |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Block can take a byte this cycle |
| tx_lanes | output | 8 | PHY data lanes out, bit 7 = lane 0 |
| tx_lane_en | output | 1 | Lanes carry a chunk this cycle |
| tx_err | output | 1 | One-cycle pulse: packet rejected for speed |
| rx_active | input | 1 | PHY presents a chunk this cycle |
| rx_first | input | 1 | Chunk starts a packet (speed sampled) |
| rx_lanes | input | 8 | PHY data lanes in, bit 7 = lane 0 |
| rx_valid | output | 1 | Rebuilt byte valid |
| rx_byte | output | 8 | Rebuilt byte |

## Verification
The hardest situation to reach is a speed change that lands in the middle of a packet. It is only visible if the serializer is still busy when `spd` moves. The bench holds a second byte pending while the first is still being cut into chunks. It switches `spd` to another legal code during that wait, then checks that the pending byte is still split at the packet's original speed with no gap. A receive packet whose second byte arrives after the code has changed gets the same treatment. Every byte value is also swept through both directions at all three speeds, and arbitrary patterns are placed on the lanes that must be ignored.

// File: rtl/lane_pkg.sv
package lane_pkg;

   typedef enum logic [1:0] {
      SPD_S100 = 2'd0,
      SPD_S200 = 2'd1,
      SPD_S400 = 2'd2,
      SPD_NONE = 2'd3
   } spd_e;

   // active lane count for a bus of width w
   function automatic int unsigned lanes_of(spd_e s, int unsigned w);
      case (s)
         SPD_S100: return w / 4;
         SPD_S200: return w / 2;
         SPD_S400: return w;
         default:  return 0;
      endcase
   endfunction

   // index of the final chunk of a byte
   function automatic logic [1:0] last_idx(spd_e s);
      case (s)
         SPD_S100: return 2'd3;
         SPD_S200: return 2'd1;
         default:  return 2'd0;
      endcase
   endfunction

   function automatic logic is_legal(spd_e s);
      return s != SPD_NONE;
   endfunction

endpackage

// File: rtl/lane_tx_ser.sv
module lane_tx_ser
   import lane_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [1:0]   spd_i,
   input  logic         valid_i,
   input  logic         first_i,
   input  logic [W-1:0] data_i,
   output logic         ready_o,
   output logic [W-1:0] lanes_o,
   output logic         en_o,
   output logic         err_o
);
   localparam logic [W-1:0] ALL1 = {W{1'b1}};

   spd_e         cur_q, eff;
   logic [W-1:0] sh_q, d_q;
   logic [1:0]   left_q;
   logic         en_q, err_q, take;
   int unsigned  n_in, n_run;
   logic [W-1:0] m_in, m_run;

   assign eff     = first_i ? spd_e'(spd_i) : cur_q;
   assign ready_o = (left_q == 2'd0);
   assign take    = valid_i && ready_o;
   assign n_in    = lanes_of(eff, W);
   assign n_run   = lanes_of(cur_q, W);
   assign m_in    = ~(ALL1 >> n_in);
   assign m_run   = ~(ALL1 >> n_run);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q  <= SPD_NONE;
         sh_q   <= '0;
         d_q    <= '0;
         left_q <= 2'd0;
         en_q   <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         err_q <= take && first_i && !is_legal(spd_e'(spd_i));
         if (take && first_i) cur_q <= spd_e'(spd_i);
         if (take && is_legal(eff)) begin
            d_q    <= data_i & m_in;
            sh_q   <= data_i << n_in;
            left_q <= last_idx(eff);
            en_q   <= 1'b1;
         end else if (left_q != 2'd0) begin
            d_q    <= sh_q & m_run;
            sh_q   <= sh_q << n_run;
            left_q <= left_q - 2'd1;
            en_q   <= 1'b1;
         end else begin
            d_q    <= '0;
            en_q   <= 1'b0;
         end
      end
   end

   assign lanes_o = d_q;
   assign en_o    = en_q;
   assign err_o   = err_q;
endmodule

// File: rtl/lane_rx_des.sv
module lane_rx_des
   import lane_pkg::*;
#(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [1:0]   spd_i,
   input  logic         active_i,
   input  logic         first_i,
   input  logic [W-1:0] lanes_i,
   output logic         valid_o,
   output logic [W-1:0] byte_o
);
   spd_e         cur_q, eff;
   logic [W-1:0] acc_q, base, nxt, out_q;
   logic [1:0]   cnt_q, cnt_b;
   logic         v_q;
   int unsigned  n;

   assign eff   = first_i ? spd_e'(spd_i) : cur_q;
   assign n     = lanes_of(eff, W);
   assign base  = first_i ? '0 : acc_q;
   assign cnt_b = first_i ? 2'd0 : cnt_q;
   assign nxt   = (base << n) | (lanes_i >> (W - n));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_q <= SPD_NONE;
         acc_q <= '0;
         cnt_q <= 2'd0;
         out_q <= '0;
         v_q   <= 1'b0;
      end else begin
         v_q <= 1'b0;
         if (active_i && first_i) cur_q <= spd_e'(spd_i);
         if (active_i && is_legal(eff)) begin
            if (cnt_b == last_idx(eff)) begin
               v_q   <= 1'b1;
               out_q <= nxt;
               acc_q <= '0;
               cnt_q <= 2'd0;
            end else begin
               acc_q <= nxt;
               cnt_q <= cnt_b + 2'd1;
            end
         end
      end
   end

   assign valid_o = v_q;
   assign byte_o  = out_q;
endmodule

// File: rtl/lane_speed_scaler.sv
module lane_speed_scaler #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [1:0]   spd,
   input  logic         tx_valid,
   input  logic         tx_first,
   input  logic [W-1:0] tx_data,
   output logic         tx_ready,
   output logic [W-1:0] tx_lanes,
   output logic         tx_lane_en,
   output logic         tx_err,
   input  logic         rx_active,
   input  logic         rx_first,
   input  logic [W-1:0] rx_lanes,
   output logic         rx_valid,
   output logic [W-1:0] rx_byte
);
   generate
      if (W < 4 || (W % 4) != 0) begin : g_bad_w
         $error("lane_speed_scaler: W must be a multiple of 4");
      end
   endgenerate

   lane_tx_ser #(.W(W)) u_tx (
      .clk(clk), .rst_n(rst_n), .spd_i(spd),
      .valid_i(tx_valid), .first_i(tx_first), .data_i(tx_data),
      .ready_o(tx_ready), .lanes_o(tx_lanes), .en_o(tx_lane_en), .err_o(tx_err)
   );

   lane_rx_des #(.W(W)) u_rx (
      .clk(clk), .rst_n(rst_n), .spd_i(spd),
      .active_i(rx_active), .first_i(rx_first), .lanes_i(rx_lanes),
      .valid_o(rx_valid), .byte_o(rx_byte)
   );
endmodule

// File: rtl/lane_speed_scaler_chk.sv
module lane_speed_scaler_chk #(
   parameter int unsigned W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic [1:0]   spd,
   input logic         tx_valid,
   input logic         tx_first,
   input logic [W-1:0] tx_data,
   input logic         tx_ready,
   input logic [W-1:0] tx_lanes,
   input logic         tx_lane_en,
   input logic         tx_err,
   input logic         rx_active,
   input logic         rx_first,
   input logic [W-1:0] rx_lanes,
   input logic         rx_valid,
   input logic [W-1:0] rx_byte
);
   AST_IDLE_LANES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_lane_en |-> tx_lanes == '0); // R5
   AST_S100_HOLDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready && tx_first && spd == 2'd0) |=> !tx_ready); // R5
   AST_S100_LOW_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready && tx_first && spd == 2'd0) |=> tx_lanes[W-3:0] == '0); // R2
   AST_S400_WHOLE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready && tx_first && spd == 2'd2) |=> tx_lane_en && tx_lanes == $past(tx_data)); // R4
   AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_err |-> $past(tx_first) && $past(tx_valid) && $past(spd) == 2'd3); // R7
   AST_ERR_NO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      tx_err |-> !tx_lane_en); // R7
   AST_RX_S400_DIRECT: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_active && rx_first && spd == 2'd2) |=> rx_valid && rx_byte == $past(rx_lanes)); // R8
   AST_RX_BAD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_active && rx_first && spd == 2'd3) |=> !rx_valid); // R10
endmodule

bind lane_speed_scaler lane_speed_scaler_chk #(.W(W)) u_chk (.*);

// File: tb/sim_lane_speed_scaler.sv
module sim_lane_speed_scaler;
   logic       clk = 1'b0;
   logic       rst_n;
   logic [1:0] spd;
   logic       tx_valid, tx_first, tx_ready, tx_lane_en, tx_err;
   logic [7:0] tx_data, tx_lanes;
   logic       rx_active, rx_first, rx_valid;
   logic [7:0] rx_lanes, rx_byte;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   lane_speed_scaler #(.W(8)) u0 (.*);

   task automatic chk(input logic ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int width_of(input int code);
      return 2 << code;
   endfunction

   function automatic logic [7:0] chunk_word(input int d, input int code, input int k);
      int n = width_of(code);
      return 8'(((d >> (8 - n * (k + 1))) & ((1 << n) - 1)) << (8 - n));
   endfunction

   task automatic tx_one(input int code, input int d, input logic first);
      int cyc = 8 / width_of(code);
      @(negedge clk);
      tx_valid = 1'b1; tx_first = first; tx_data = 8'(d); spd = 2'(code);
      @(posedge clk); #1;
      tx_valid = 1'b0; tx_first = 1'b0;
      for (int k = 0; k < cyc; k++) begin
         @(negedge clk);
         // R2 R3 R4 chunking, R5 ready pattern
         chk(tx_lanes == chunk_word(d, code, k) && tx_lane_en && (tx_ready == (k == cyc - 1)),
             $sformatf("R2/R3/R4/R5 tx code=%0d chunk=%0d", code, k),
             {tx_lane_en, tx_ready, tx_lanes}, {1'b1, k == cyc - 1, chunk_word(d, code, k)});
      end
      @(negedge clk);
      chk(!tx_lane_en && tx_lanes == 8'h00, "R5 tx idle after byte", {tx_lane_en, tx_lanes}, 0);
   endtask

   task automatic rx_one(input int code, input int d, input logic first, input int junk);
      int cyc = 8 / width_of(code);
      int n = width_of(code);
      for (int k = 0; k < cyc; k++) begin
         @(negedge clk);
         rx_active = 1'b1; rx_first = first && (k == 0); spd = 2'(code);
         rx_lanes = chunk_word(d, code, k) | 8'(junk & ((1 << (8 - n)) - 1));
      end
      @(negedge clk);
      rx_active = 1'b0; rx_first = 1'b0;
      // R8 R9 reassembly with ignored lanes
      chk(rx_valid && rx_byte == 8'(d), $sformatf("R8/R9 rx code=%0d", code),
          {rx_valid, rx_byte}, {1'b1, 8'(d)});
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_bad++; n_chk++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      rst_n = 1'b0; spd = 2'd0;
      tx_valid = 1'b0; tx_first = 1'b0; tx_data = 8'h00;
      rx_active = 1'b0; rx_first = 1'b0; rx_lanes = 8'h00;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      // R1
      chk(tx_lanes == 0 && !tx_lane_en && tx_ready && !tx_err && !rx_valid, "R1 reset state",
          {tx_lanes, tx_lane_en, tx_ready, tx_err, rx_valid}, {8'h00, 4'b0100});

      // sweep of all bytes at all speeds, both directions
      for (int c = 0; c < 3; c++)
         for (int d = 0; d < 256; d++) begin
            tx_one(c, d, 1'b1);
            rx_one(c, d, 1'b1, (d * 37 + 11) & 8'hFF);
         end

      // R5/R6: back-to-back at code 1, spd changed while second byte waits
      @(negedge clk);
      tx_valid = 1'b1; tx_first = 1'b1; tx_data = 8'hA7; spd = 2'd1;
      @(posedge clk); #1;
      tx_first = 1'b0; tx_data = 8'h3C; spd = 2'd0;
      @(negedge clk);
      chk(tx_lanes == 8'hA0 && !tx_ready, "R5 b2b first chunk", {tx_ready, tx_lanes}, 8'hA0);
      @(negedge clk);
      chk(tx_lanes == 8'h70 && tx_ready, "R5 b2b second chunk", {tx_ready, tx_lanes}, 9'h170);
      @(posedge clk); #1;
      tx_valid = 1'b0;
      @(negedge clk);
      chk(tx_lanes == 8'h30 && tx_lane_en, "R6 next byte keeps code 1 (hi)", tx_lanes, 8'h30);
      @(negedge clk);
      chk(tx_lanes == 8'hC0 && tx_lane_en, "R6 next byte keeps code 1 (lo)", tx_lanes, 8'hC0);
      @(negedge clk);
      chk(!tx_lane_en && tx_lanes == 0, "R5 idle after pair", {tx_lane_en, tx_lanes}, 0);

      // R7: unsupported code rejected
      @(negedge clk);
      tx_valid = 1'b1; tx_first = 1'b1; tx_data = 8'hFF; spd = 2'd3;
      @(posedge clk); #1;
      tx_first = 1'b0; tx_data = 8'h81; spd = 2'd2;
      @(negedge clk);
      chk(tx_err && !tx_lane_en && tx_lanes == 0, "R7 error pulse, no lanes",
          {tx_err, tx_lane_en, tx_lanes}, 10'h200);
      @(posedge clk); #1;
      tx_valid = 1'b0;
      @(negedge clk);
      chk(!tx_err && !tx_lane_en && tx_lanes == 0, "R7 rest of packet dropped",
          {tx_err, tx_lane_en, tx_lanes}, 0);
      tx_one(2, 8'h5E, 1'b1);

      // R10: receive packet, second byte after spd changes
      rx_one(0, 8'hC9, 1'b1, 8'h3F);
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         rx_active = 1'b1; rx_first = 1'b0; spd = 2'd2;
         rx_lanes = chunk_word(8'h4B, 0, k) | 8'h2A;
      end
      @(negedge clk);
      rx_active = 1'b0;
      chk(rx_valid && rx_byte == 8'h4B, "R10 rx keeps packet code", {rx_valid, rx_byte}, 9'h14B);

      // R10: unsupported code produces nothing
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         rx_active = 1'b1; rx_first = (k == 0); spd = 2'd3; rx_lanes = 8'hE4;
         if (k > 0) chk(!rx_valid, "R10 rx bad code silent", rx_valid, 0);
      end
      @(negedge clk);
      rx_active = 1'b0; rx_first = 1'b0;
      chk(!rx_valid, "R10 rx bad code silent end", rx_valid, 0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule